// File: doc/BRIEF.md
# Refresh Interval Timer

This block paces the refresh requests sent to a dynamic memory controller. A 6-bit reload value sets how many prescaled ticks lie between requests. A two-stage prescaler produces those ticks. The first stage is an optional divide-by-8 stage, and the second is a fixed divide-by-32 stage. A clock-select field picks whether the first stage is used.

Software starts the timer through a small write port. When the run bit goes from 0 to 1, the counter loads the reload value. Each time the counter passes through zero on a tick, it reloads. If the external refresh-enable input is also high at that moment, the block raises a single-cycle request. The refresh command sequence and the memory pins belong to other blocks.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset, the run bit is 0, the clock select is 00, the reload value is 0 and `ref_req` is low. No request is issued while the run bit is 0.
- R2: A write that takes the run bit from 0 to 1 loads the reload value into the counter and starts the prescaler from zero. With clock select 00, the first request appears (reload+1)*32 clocks after that write edge.
- R3: With clock select 01, the base clock is first divided by 8, so requests are spaced (reload+1)*256 clocks apart. With reload 63 this gives 16384 clocks.
- R4: With clock select 10 or 11, the counter holds its value, the prescaler stays cleared and no request is issued. Once a valid code is written, counting resumes from the held value and the prescaler starts from zero.
- R5: A request is issued only while both the run bit and `ref_en` are 1. While `ref_en` is low, the counter still runs and reloads.
- R6: Each request is high for exactly one clock. The counter reloads on underflow, so requests repeat with a steady period.
- R7: Clearing the run bit freezes the counter, clears the prescaler and drops any request that would otherwise follow.
- R8: A reload value written while the timer runs takes effect at the next reload, not in the middle of a count.
- R9: A reload value of 0 gives a request on every prescaled tick.
- R10: The write port has two addresses. At `cfg_addr`=0, bit 0 is the run bit and bits 2:1 are the clock select. At `cfg_addr`=1, bits 5:0 are the reload value. A write to address 1 never changes the run bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control, 1 = reload |
| cfg_wdata | input | 8 | Write data |
| ref_en | input | 1 | External refresh enable |
| ref_req | output | 1 | One-cycle refresh request |

## Verification
The assertions check, on every cycle, that a request is never longer than one clock. They also check that a request requires both enables and a valid clock select, that the counter is stable between ticks and loads, and that the prescaler is held at zero while the timer is stopped. Only the bench scenarios can show the actual request spacing for each clock select and reload value. The same holds for resuming after a reserved code, for the delayed effect of a reload write and for the prescaler restart after a stop.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int DATA_W = 8;
  localparam logic ADDR_CTRL   = 1'b0;
  localparam logic ADDR_RELOAD = 1'b1;

  typedef enum logic [1:0] {
    SEL_FAST  = 2'b00,
    SEL_SLOW  = 2'b01,
    SEL_RSV_A = 2'b10,
    SEL_RSV_B = 2'b11
  } clk_sel_e;

  function automatic logic sel_valid(input clk_sel_e s);
    return (s == SEL_FAST) || (s == SEL_SLOW);
  endfunction
endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler #(
  parameter int PRE_DIV  = 32,
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int PW = $clog2(PRE_DIV);
  localparam int SW = $clog2(SLOW_DIV);

  logic [SW-1:0] slow_q;
  logic [PW-1:0] pre_q;
  logic          base_tick;

  always_comb begin
    base_tick = !slow_i || (slow_q == SW'(SLOW_DIV - 1));
    tick_o    = en_i && base_tick && (pre_q == PW'(PRE_DIV - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      slow_q <= '0;
      pre_q  <= '0;
    end else begin
      if (slow_i)
        slow_q <= (slow_q == SW'(SLOW_DIV - 1)) ? '0 : slow_q + 1'b1;
      else
        slow_q <= '0;
      if (base_tick)
        pre_q <= (pre_q == PW'(PRE_DIV - 1)) ? '0 : pre_q + 1'b1;
    end
  end

  // prescaler restarts from zero after a stop (R7)
  assert_pre_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (pre_q == '0 && slow_q == '0));
endmodule

// File: rtl/rit_down_counter.sv
module rit_down_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             zero_tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb zero_tick_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= reload_i;
    else if (tick_i)
      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  // start edge captures the reload value (R2)
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(reload_i)));
  // counter holds between ticks, also under reserved select (R4)
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int CNT_W    = 6,
  parameter int PRE_DIV  = 32,
  parameter int SLOW_DIV = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic                       cfg_addr,
  input  logic [rit_pkg::DATA_W-1:0] cfg_wdata,
  input  logic                       ref_en,
  output logic                       ref_req
);
  import rit_pkg::*;

  logic             run_q;
  clk_sel_e         sel_q;
  logic [CNT_W-1:0] reload_q;
  logic             running;
  logic             load;
  logic             tick;
  logic             zero_tick;

  // R10: control at address 0 (bit0 run, bits 2:1 select), reload at address 1
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      sel_q    <= SEL_FAST;
      reload_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_CTRL) begin
        run_q <= cfg_wdata[0];
        sel_q <= clk_sel_e'(cfg_wdata[2:1]);
      end else begin
        reload_q <= cfg_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    load    = cfg_we && (cfg_addr == ADDR_CTRL) && cfg_wdata[0] && !run_q;
    running = run_q && sel_valid(sel_q);
  end

  rit_prescaler #(.PRE_DIV(PRE_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .en_i   (running),
    .slow_i (sel_q == SEL_SLOW),
    .tick_o (tick)
  );

  rit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .tick_i      (tick),
    .reload_i    (reload_q),
    .zero_tick_o (zero_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_req <= 1'b0;
    else     ref_req <= zero_tick && ref_en;
  end

  assert_req_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    ref_req |=> !ref_req);
  assert_req_enables_R5: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> $past(run_q && ref_en));
  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_valid(sel_q) |=> !ref_req);
  assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !ref_req);
endmodule

// File: tb/sim_refresh_interval_timer.sv
module sim_refresh_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       ref_en = 1'b0;
  logic       ref_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_interval_timer u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ref_en(ref_en), .ref_req(ref_req)
  );

  // sel, reload, expected first latency (= steady period)
  localparam int NV = 6;
  localparam int V_SEL [NV] = '{0, 0, 0, 1, 1, 1};
  localparam int V_REL [NV] = '{0, 5, 63, 0, 3, 63};
  localparam int V_EXP [NV] = '{32, 192, 2048, 256, 1024, 16384};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R10 encodings: ctrl = {sel, run} at addr 0, reload at addr 1
  task automatic wr_ctrl(input int sel, input bit run);
    wr(1'b0, {5'b0, 2'(sel), run});
  endtask

  task automatic wait_req(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ref_req) begin seen = 1; return; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    bit seen;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ref_req == 1'b0, "R1 reset req", ref_req, 0);
    ref_en = 1'b1;
    wait_req(100, seen);
    chk(!seen, "R1 stopped no req", seen, 0);

    // R10: write to reload address with bit0 set must not start
    wr(1'b1, 8'h01);
    wait_req(100, seen);
    chk(!seen, "R10 reload write no start", seen, 0);

    // vector table: R2 (sel 00), R3 (sel 01), R9 (reload 0), R6 period/width
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, 8'(V_REL[v]));
      wr_ctrl(V_SEL[v], 1'b1);
      t0 = cyc;
      wait_req(20000, seen);
      chk(seen && (cyc - t0) == V_EXP[v],
          (V_SEL[v] == 0) ? ((V_REL[v] == 0) ? "R9 first latency" : "R2 first latency")
                          : "R3 first latency", cyc - t0, V_EXP[v]);
      t1 = cyc;
      @(negedge clk);
      chk(ref_req == 1'b0, "R6 one-cycle width", ref_req, 0);
      wait_req(20000, seen);
      chk(seen && (cyc - t1) == V_EXP[v], "R6 steady period", cyc - t1, V_EXP[v]);
      wr_ctrl(0, 1'b0);
    end

    // R5: ref_en low suppresses requests but counter keeps running
    ref_en = 1'b0;
    wr(1'b1, 8'd1);
    wr_ctrl(0, 1'b1);
    t0 = cyc;
    wait_req(100, seen);
    chk(!seen, "R5 no req with ref_en low", seen, 0);
    ref_en = 1'b1;
    wait_req(1000, seen);
    chk(seen && (cyc - t0) == 128, "R5 counter kept running", cyc - t0, 128);
    wr_ctrl(0, 1'b0);

    // R4: reserved select holds count; resume from held value
    wr(1'b1, 8'd2);
    wr_ctrl(0, 1'b1);
    t0 = cyc;
    while (cyc - t0 < 40) @(negedge clk);
    wr_ctrl(3, 1'b1);
    wait_req(300, seen);
    chk(!seen, "R4 reserved 11 no req", seen, 0);
    wr_ctrl(2, 1'b1);
    wait_req(300, seen);
    chk(!seen, "R4 reserved 10 no req", seen, 0);
    wr_ctrl(0, 1'b1);
    t1 = cyc;
    wait_req(1000, seen);
    chk(seen && (cyc - t1) == 64, "R4 resume from held count", cyc - t1, 64);
    wr_ctrl(0, 1'b0);

    // R7: stop drops pending request and clears prescaler
    wr(1'b1, 8'd0);
    wr_ctrl(0, 1'b1);
    t0 = cyc;
    while (cyc - t0 < 20) @(negedge clk);
    wr_ctrl(0, 1'b0);
    wait_req(100, seen);
    chk(!seen, "R7 stop drops request", seen, 0);
    wr_ctrl(0, 1'b1);
    t1 = cyc;
    wait_req(1000, seen);
    chk(seen && (cyc - t1) == 32, "R7 prescaler restarted", cyc - t1, 32);
    wr_ctrl(0, 1'b0);

    // R8: reload change mid-count applies at next reload
    wr(1'b1, 8'd3);
    wr_ctrl(0, 1'b1);
    t0 = cyc;
    while (cyc - t0 < 10) @(negedge clk);
    wr(1'b1, 8'd0);
    wait_req(1000, seen);
    chk(seen && (cyc - t0) == 128, "R8 current count unaffected", cyc - t0, 128);
    t1 = cyc;
    wait_req(1000, seen);
    chk(seen && (cyc - t1) == 32, "R8 new reload used", cyc - t1, 32);
    wr_ctrl(0, 1'b0);

    finish_run();
  end
endmodule